// File: doc/BRIEF.md
# Command-Sequenced Add/Subtract Unit

This block is a small arithmetic datapath run by a controlling state machine. It holds two operand registers and one result register. Three command strobes drive it. A load command captures both operand inputs. A compute command reads the stored operands, adds or subtracts them, and keeps the outcome in the result register. A show command drives that stored outcome onto the output port for one cycle.

Every register has its own write-enable and output-enable, and the state machine alone drives them. Each command stage lasts one clock cycle. When several strobes are high on the same edge, load wins over compute, and compute wins over show. The remaining strobes on that edge are dropped and are not queued.

Top module: `salu_top`

## Requirements
- R1: A synchronous active-low reset clears both operand registers and the result register and returns the machine to idle; afterwards `res_valid` is 0, `res_out` is 0, and a later show command presents 0.
- R2: A load command sampled at clock edge k makes the operand registers capture `a_in` and `b_in` at edge k+1. The operand inputs must therefore be held through edge k+1.
- R3: A compute command with `op_sub`=0 stores {1'b0,A}+{1'b0,B} as an N+1 bit value, so the carry is kept, at edge k+1.
- R4: A compute command with `op_sub`=1 stores ({1'b0,A}-{1'b0,B}) modulo 2^(N+1), which is two's complement A minus B, at edge k+1. Both operations can be applied to the same stored operands.
- R5: A show command sampled at edge k drives `res_out` with the stored result and `res_valid`=1 for exactly the one cycle between edges k and k+1.
- R6: Outside a show stage, `res_valid` is 0 and `res_out` is 0.
- R7: Load has the highest priority. If load is high together with compute and/or show, only the operands are loaded: the result register is unchanged and no output is shown.
- R8: Compute beats show. If both are high and load is low, the result is updated and nothing is shown on that stage.
- R9: The result register changes only in a compute stage. Repeated show commands present the same value.
- R10: Changes on `a_in`/`b_in` without a load command do not alter the stored operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_cmd | input | 1 | Load-operands command strobe |
| ex_cmd | input | 1 | Compute command strobe |
| show_cmd | input | 1 | Show-result command strobe |
| op_sub | input | 1 | Operation select during compute: 0 add, 1 subtract |
| a_in | input | N | First operand input |
| b_in | input | N | Second operand input |
| res_out | output | N+1 | Shown result, zero when not showing |
| res_valid | output | 1 | High during the show stage |

## Verification
Every command is sampled on one edge, and its stage occupies the following cycle. Operands and the result commit at the end of that stage. The shown value is visible during the stage itself.

The bench drives a strobe on a falling edge and removes it on the next falling edge. It then samples the outputs at once, which is mid-stage for a show command. It samples again one falling edge later to confirm that the valid pulse has ended. Operand and operation inputs are held until the next load command, so the commit edge always sees stable data.

Stored values that are not visible directly are checked through a later show command.

// File: rtl/salu_pkg.sv
// Package: shared types for the command-sequenced add/subtract unit.
// Assumes: one stage per clock cycle, the state encoding is internal.
package salu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_EXEC = 2'd2,
        ST_SHOW = 2'd3
    } salu_state_t;

    localparam int unsigned NUM_OPND = 2;
endpackage

// File: rtl/salu_reg.sv
// Module: salu_reg
// A W-bit storage register with a write-enable and a gated output.
// The gated output reads zero while the output-enable is low; q_raw is the raw content.
// Assumes: synchronous active-low reset, and d is stable at the edge where we is high.
module salu_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic         oe,
    input  logic [W-1:0] d,
    output logic [W-1:0] q_gated,
    output logic [W-1:0] q_raw
);
    logic [W-1:0] q;

    // Storage: cleared by reset, loaded only when write-enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
    end

    // Read port: content is visible only while output-enabled.
    always_comb q_gated = oe ? q : '0;

    assign q_raw = q;

    // R9/R10: content holds whenever the write-enable was low.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> q == $past(q));
endmodule

// File: rtl/salu_arith.sv
// Module: salu_arith
// Combinational N-bit add/subtract that produces an N+1 bit result.
// Add keeps the carry. Subtract is the two's complement difference modulo 2^(N+1).
// Assumes: the operands arrive zero when their registers are not output-enabled.
module salu_arith #(
    parameter int unsigned N = 8
) (
    input  logic         sub,
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N:0]   y
);
    logic [N:0] a_x, b_x;

    // Zero-extend both operands to the result width.
    always_comb begin
        a_x = {1'b0, a};
        b_x = {1'b0, b};
    end

    // Select the operation.
    always_comb y = sub ? (a_x - b_x) : (a_x + b_x);
endmodule

// File: rtl/salu_ctrl.sv
// Module: salu_ctrl
// Stage sequencer. Each clock edge it picks the next stage from the command strobes, with load over compute over show.
// Every stage lasts one cycle. The enables for the registers are decoded from the current stage.
// Assumes: synchronous active-low reset, and strobes are sampled on the rising edge.
module salu_ctrl
    import salu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_cmd,
    input  logic ex_cmd,
    input  logic show_cmd,
    output logic opnd_we,
    output logic opnd_oe,
    output logic res_we,
    output logic res_oe
);
    salu_state_t state_q, state_d;

    // Priority resolution of the command strobes.
    always_comb begin
        if (wr_cmd)        state_d = ST_LOAD;
        else if (ex_cmd)   state_d = ST_EXEC;
        else if (show_cmd) state_d = ST_SHOW;
        else               state_d = ST_IDLE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Enable decode for the current stage.
    always_comb begin
        opnd_we = (state_q == ST_LOAD);
        opnd_oe = (state_q == ST_EXEC);
        res_we  = (state_q == ST_EXEC);
        res_oe  = (state_q == ST_SHOW);
    end

    p_load_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd |=> state_q == ST_LOAD);
    p_exec_over_show_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cmd && ex_cmd) |=> state_q == ST_EXEC);
    p_show_stage_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cmd && !ex_cmd && show_cmd) |=> state_q == ST_SHOW);
    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_cmd || ex_cmd || show_cmd) |=> state_q == ST_IDLE);
endmodule

// File: rtl/salu_top.sv
// Module: salu_top
// Command-sequenced add/subtract unit: two operand registers and one result register, sequenced by salu_ctrl.
// Assumes: a_in, b_in and op_sub stay stable through the stage that uses them.
module salu_top
    import salu_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_cmd,
    input  logic         ex_cmd,
    input  logic         show_cmd,
    input  logic         op_sub,
    input  logic [N-1:0] a_in,
    input  logic [N-1:0] b_in,
    output logic [N:0]   res_out,
    output logic         res_valid
);
    localparam int unsigned RW = N + 1;

    logic opnd_we, opnd_oe, res_we, res_oe;
    logic [NUM_OPND-1:0][N-1:0] opnd_d, opnd_rd, opnd_raw;
    logic [RW-1:0] sum_w, res_raw;

    salu_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_cmd(wr_cmd), .ex_cmd(ex_cmd), .show_cmd(show_cmd),
        .opnd_we(opnd_we), .opnd_oe(opnd_oe),
        .res_we(res_we), .res_oe(res_oe)
    );

    // Operand input gather.
    always_comb begin
        opnd_d[0] = a_in;
        opnd_d[1] = b_in;
    end

    for (genvar gi = 0; gi < NUM_OPND; gi++) begin : g_opnd
        salu_reg #(.W(N)) u_opnd (
            .clk(clk), .rst_n(rst_n),
            .we(opnd_we), .oe(opnd_oe),
            .d(opnd_d[gi]), .q_gated(opnd_rd[gi]), .q_raw(opnd_raw[gi])
        );
    end

    salu_arith #(.N(N)) u_arith (
        .sub(op_sub), .a(opnd_rd[0]), .b(opnd_rd[1]), .y(sum_w)
    );

    salu_reg #(.W(RW)) u_res (
        .clk(clk), .rst_n(rst_n),
        .we(res_we), .oe(res_oe),
        .d(sum_w), .q_gated(res_out), .q_raw(res_raw)
    );

    assign res_valid = res_oe;

    p_out_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> res_out == '0);
    p_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && !op_sub) |=>
        res_raw == ({1'b0, $past(opnd_raw[0])} + {1'b0, $past(opnd_raw[1])}));
    p_sub_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && op_sub) |=>
        res_raw == ({1'b0, $past(opnd_raw[0])} - {1'b0, $past(opnd_raw[1])}));
    p_show_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_out == res_raw);
endmodule

// File: tb/salu_top_tb_top.sv
module salu_top_tb_top;
    localparam int N = 4;
    localparam int M = 1 << (N + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_cmd = 0, ex_cmd = 0, show_cmd = 0, op_sub = 0;
    logic [N-1:0] a_in = '0, b_in = '0;
    logic [N:0] res_out;
    logic res_valid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    salu_top #(.N(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .ex_cmd(ex_cmd),
        .show_cmd(show_cmd), .op_sub(op_sub), .a_in(a_in), .b_in(b_in),
        .res_out(res_out), .res_valid(res_valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Strobe commands for one edge; returns at the falling edge inside the stage.
    task automatic cmd(input bit w, input bit e, input bit s);
        @(negedge clk);
        wr_cmd = w; ex_cmd = e; show_cmd = s;
        @(negedge clk);
        wr_cmd = 0; ex_cmd = 0; show_cmd = 0;
    endtask

    // Show, check value during the stage, check the pulse ends one cycle later.
    task automatic show_expect(input int exp, input string tag);
        cmd(0, 0, 1);
        chk(res_valid === 1'b1, tag, int'(res_valid), 1);
        chk(res_out === exp[N:0], tag, int'(res_out), exp);
        @(negedge clk);
        chk(res_valid === 1'b0, "R5 pulse width", int'(res_valid), 0);
        chk(res_out === '0, "R6 quiet output", int'(res_out), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(res_valid === 1'b0, "R1 valid in reset", int'(res_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_out === '0, "R1 out after reset", int'(res_out), 0);
        show_expect(0, "R1 cleared result");
        op_sub = 0;
        cmd(0, 1, 0);
        show_expect(0, "R1 cleared operands");

        // R2 R3 R4: sweep all operand pairs with both operations
        for (int a = 0; a < (1 << N); a++) begin
            for (int b = 0; b < (1 << N); b++) begin
                a_in = a[N-1:0]; b_in = b[N-1:0];
                cmd(1, 0, 0);
                op_sub = 0;
                cmd(0, 1, 0);
                chk(res_valid === 1'b0, "R6 no show in compute", int'(res_valid), 0);
                show_expect(a + b, "R3 add");
                op_sub = 1;
                cmd(0, 1, 0);
                show_expect((a - b + M) % M, "R4 sub");
            end
        end

        // R9: repeated shows keep the value
        show_expect((15 - 15 + M) % M, "R9 repeat show");

        // R10: inputs change without load
        a_in = 4'd9; b_in = 4'd3; op_sub = 0;
        cmd(0, 1, 0);
        show_expect(30, "R10 operands unchanged");

        // R7: load together with compute: result keeps 30, operands become 9,3
        cmd(1, 1, 0);
        show_expect(30, "R7 load over compute");
        cmd(0, 1, 0);
        show_expect(12, "R2 loaded in load+compute");

        // R7: all three high, nothing shown
        a_in = 4'd7; b_in = 4'd2;
        cmd(1, 1, 1);
        chk(res_valid === 1'b0, "R7 no show with load", int'(res_valid), 0);
        op_sub = 1;
        cmd(0, 1, 0);
        show_expect(5, "R7 operands loaded");

        // R8: compute over show
        op_sub = 0;
        cmd(0, 1, 1);
        chk(res_valid === 1'b0, "R8 no show with compute", int'(res_valid), 0);
        show_expect(9, "R8 result updated");

        // R7: load with show only
        a_in = 4'd1; b_in = 4'd1;
        cmd(1, 0, 1);
        chk(res_valid === 1'b0, "R7 no show with load", int'(res_valid), 0);
        show_expect(9, "R7 result kept");

        // R1: reset mid-run clears everything
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        show_expect(0, "R1 reset clears result");
        cmd(0, 1, 0);
        show_expect(0, "R1 reset clears operands");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule